// File: doc/BRIEF.md
# Raster Position Tracker

This block follows a video raster using nothing more than the composite blanking and sync levels, sampled on the pixel clock. From these two levels it works out three things: the column of the current pixel, the line number within the frame, and whether vertical retrace is in progress. A cursor overlay can use the results directly. A one-cycle pulse marks the first pixel of each frame, so that per-frame state elsewhere can be reloaded at that point.

A line begins on each rising edge of the blanking input, with blanking high meaning active video. Vertical retrace is recognised when a second sync rising edge arrives inside one blanking interval. The next line then becomes line 0. In interlaced operation a field input is sampled as line 0 begins. Line 0 carries number 1 in an odd field and number 0 in an even field, and each following line in the field adds two. The inputs are synchronous to the pixel clock and go through one register stage, so every output describes the pixel presented one clock earlier.

Top module: `raster_pos_tracker`

## Requirements
- R1: While reset is held, and in the first cycle after reset, all outputs are zero.
- R2: `active_o` equals the value `blank_in` had one clock earlier.
- R3: `pix_x_o` is 0 for the first pixel after a rising edge of `blank_in`. It rises by one on each later cycle with `blank_in` high and holds its value while `blank_in` is low.
- R4: `pix_x_o` saturates at 2^X_W-1 and does not wrap.
- R5: A sync rising edge seen while `blank_in` is high has no effect. The count of sync edges restarts at every rising edge of `blank_in`, so single edges in separate blanking intervals never add up to a retrace.
- R6: `vretrace_o` rises one cycle after the second sync rising edge within a single blanking interval. Further edges keep it high, and it falls at the first pixel of the next line.
- R7: The first line after a retrace is line 0. On its first pixel `frame_start_o` is high for exactly one cycle. In progressive mode (`interlace_in`=0) `line_y_o` is 0 on that line.
- R8: Every other rising edge of `blank_in` adds 1 to `line_y_o` in progressive mode and 2 in interlaced mode. The value saturates at 2^Y_W-1.
- R9: In interlaced mode `odd_field_in` is sampled as line 0 begins. Line 0 then carries `line_y_o` = 1 when the input is 1 (odd field) and 0 when it is 0 (even field).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank_in | input | 1 | Composite blanking level, high during active video |
| sync_in | input | 1 | Composite sync level, active high |
| odd_field_in | input | 1 | Field identity, 1 = odd field |
| interlace_in | input | 1 | 1 selects interlaced line numbering |
| pix_x_o | output | X_W (12) | Column of the current pixel |
| line_y_o | output | Y_W (11) | Line of the current pixel within the frame |
| active_o | output | 1 | Current pixel lies inside active video |
| frame_start_o | output | 1 | One-cycle pulse on the first pixel of line 0 |
| vretrace_o | output | 1 | Vertical retrace in progress |

## Verification
The bench gives single sync pulses in two blanking intervals in a row. A tracker that failed to clear its edge count would declare a false retrace there and restart the frame. Sync pulses placed inside active video are aimed at a design that counts edges regardless of blanking, and three pulses in one interval check that retrace stays asserted rather than toggling. A 4100-pixel line and a long run of lines drive both counters past full scale, where a wrapping counter would jump back to small values. Interlaced frames of both parities catch a swapped field start or a step of one.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
   typedef enum logic {
      FIELD_EVEN = 1'b0,
      FIELD_ODD  = 1'b1
   } rpt_field_e;

   typedef struct packed {
      logic sync_lvl;
      logic blank_lvl;
   } rpt_inputs_t;

   localparam int RPT_IN_COUNT = 2;
endpackage

// File: rtl/rpt_edge_detect.sv
module rpt_edge_detect #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] prev_o,
   output logic [N-1:0] rise_o
);
   if (N < 1) begin : g_bad_n
      $error("rpt_edge_detect: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= lvl_i[i];
      end
      assign prev_o[i] = q;
      assign rise_o[i] = lvl_i[i] & ~q;
   end
endmodule

// File: rtl/rpt_retrace_detect.sv
module rpt_retrace_detect #(
   parameter int EDGES = 2,
   localparam int CNT_W = $clog2(EDGES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blank_lvl_i,
   input  logic blank_rise_i,
   input  logic sync_rise_i,
   output logic vretrace_o
);
   if (EDGES < 1) begin : g_bad_edges
      $error("rpt_retrace_detect: EDGES must be at least 1");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(EDGES);

   logic [CNT_W-1:0] edge_cnt;
   logic             count_ok;

   assign count_ok = sync_rise_i && !blank_lvl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt   <= '0;
         vretrace_o <= 1'b0;
      end else if (blank_rise_i) begin
         edge_cnt   <= '0;
         vretrace_o <= 1'b0;
      end else if (count_ok && edge_cnt != TOP) begin
         edge_cnt <= edge_cnt + 1'b1;
         if (edge_cnt == LAST) vretrace_o <= 1'b1;
      end
   end

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= TOP);
   assert_active_sync_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_rise_i && blank_lvl_i && !blank_rise_i) |=> $stable(edge_cnt));
   assert_retrace_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      blank_rise_i |=> !vretrace_o);
   assert_retrace_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vretrace_o && !blank_rise_i) |=> vretrace_o);
endmodule

// File: rtl/rpt_pixel_counter.sv
module rpt_pixel_counter #(
   parameter int X_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           blank_lvl_i,
   input  logic           blank_rise_i,
   output logic [X_W-1:0] x_o
);
   if (X_W < 2) begin : g_bad_xw
      $error("rpt_pixel_counter: X_W must be at least 2");
   end

   localparam logic [X_W-1:0] X_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         x_o <= '0;
      else if (blank_rise_i)              x_o <= '0;
      else if (blank_lvl_i && x_o != X_MAX) x_o <= x_o + 1'b1;
   end

   assert_x_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      blank_rise_i |=> (x_o == '0));
   assert_x_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_lvl_i |=> $stable(x_o));
   assert_x_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (x_o == X_MAX && !blank_rise_i) |=> (x_o == X_MAX));
endmodule

// File: rtl/rpt_line_counter.sv
module rpt_line_counter #(
   parameter int Y_W = 11,
   parameter bit INTERLACE_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           blank_rise_i,
   input  logic           vretrace_i,
   input  logic           interlace_i,
   input  logic           odd_field_i,
   output logic [Y_W-1:0] y_o,
   output logic           frame_start_o
);
   import rpt_pkg::*;

   if (Y_W < 2) begin : g_bad_yw
      $error("rpt_line_counter: Y_W must be at least 2");
   end

   localparam logic [Y_W:0]   Y_MAX_W = {1'b0, {Y_W{1'b1}}};
   localparam logic [Y_W-1:0] Y_MAX   = '1;

   logic [Y_W-1:0] step;
   logic [Y_W-1:0] first_line;
   logic [Y_W:0]   sum;

   if (INTERLACE_EN) begin : g_interlace
      rpt_field_e field;
      assign field      = rpt_field_e'(odd_field_i);
      assign step       = interlace_i ? Y_W'(2) : Y_W'(1);
      assign first_line = (interlace_i && field == FIELD_ODD) ? Y_W'(1) : '0;
   end else begin : g_progressive
      assign step       = Y_W'(1);
      assign first_line = '0;
   end

   assign sum = {1'b0, y_o} + {1'b0, step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_o           <= '0;
         frame_start_o <= 1'b0;
      end else begin
         frame_start_o <= blank_rise_i && vretrace_i;
         if (blank_rise_i) begin
            if (vretrace_i)          y_o <= first_line;
            else if (sum > Y_MAX_W)  y_o <= Y_MAX;
            else                     y_o <= sum[Y_W-1:0];
         end
      end
   end

   assert_frame_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_rise_i && vretrace_i && !interlace_i) |=> (frame_start_o && y_o == '0));
   assert_frame_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> !frame_start_o);
   assert_line_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_rise_i && !vretrace_i && !interlace_i && y_o != Y_MAX)
      |=> (y_o == $past(y_o) + 1'b1));
   assert_line_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_rise_i && !vretrace_i && y_o == Y_MAX) |=> (y_o == Y_MAX));
   assert_field_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_rise_i && vretrace_i && interlace_i && odd_field_i && INTERLACE_EN)
      |=> (y_o == Y_W'(1)));
endmodule

// File: rtl/raster_pos_tracker.sv
module raster_pos_tracker #(
   parameter int X_W = 12,
   parameter int Y_W = 11,
   parameter int RETRACE_EDGES = 2,
   parameter bit INTERLACE_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           blank_in,
   input  logic           sync_in,
   input  logic           odd_field_in,
   input  logic           interlace_in,
   output logic [X_W-1:0] pix_x_o,
   output logic [Y_W-1:0] line_y_o,
   output logic           active_o,
   output logic           frame_start_o,
   output logic           vretrace_o
);
   import rpt_pkg::*;

   rpt_inputs_t lvl, prev, rise;
   logic        vretrace;

   assign lvl.blank_lvl = blank_in;
   assign lvl.sync_lvl  = sync_in;

   rpt_edge_detect #(.N(RPT_IN_COUNT)) u_edges (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .prev_o (prev),
      .rise_o (rise)
   );

   assign active_o = prev.blank_lvl;

   rpt_retrace_detect #(.EDGES(RETRACE_EDGES)) u_retrace (
      .clk          (clk),
      .rst_n        (rst_n),
      .blank_lvl_i  (blank_in),
      .blank_rise_i (rise.blank_lvl),
      .sync_rise_i  (rise.sync_lvl),
      .vretrace_o   (vretrace)
   );

   assign vretrace_o = vretrace;

   rpt_pixel_counter #(.X_W(X_W)) u_pix (
      .clk          (clk),
      .rst_n        (rst_n),
      .blank_lvl_i  (blank_in),
      .blank_rise_i (rise.blank_lvl),
      .x_o          (pix_x_o)
   );

   rpt_line_counter #(.Y_W(Y_W), .INTERLACE_EN(INTERLACE_EN)) u_line (
      .clk           (clk),
      .rst_n         (rst_n),
      .blank_rise_i  (rise.blank_lvl),
      .vretrace_i    (vretrace),
      .interlace_i   (interlace_in),
      .odd_field_i   (odd_field_in),
      .y_o           (line_y_o),
      .frame_start_o (frame_start_o)
   );

   assert_active_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> (pix_x_o == '0));
   assert_start_needs_retrace_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |-> (active_o && !vretrace_o));
endmodule

// File: tb/raster_pos_tracker_test.sv
module raster_pos_tracker_test;
   localparam int XW = 12;
   localparam int YW = 11;
   localparam int XMAX = (1 << XW) - 1;
   localparam int YMAX = (1 << YW) - 1;

   typedef struct {
      int x; int y; bit a; bit fs; bit vr;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic blank_in = 1'b0, sync_in = 1'b0, odd_field_in = 1'b0, interlace_in = 1'b0;
   logic [XW-1:0] pix_x_o;
   logic [YW-1:0] line_y_o;
   logic active_o, frame_start_o, vretrace_o;

   always #2 clk = ~clk;

   raster_pos_tracker uut (
      .clk(clk), .rst_n(rst_n), .blank_in(blank_in), .sync_in(sync_in),
      .odd_field_in(odd_field_in), .interlace_in(interlace_in),
      .pix_x_o(pix_x_o), .line_y_o(line_y_o), .active_o(active_o),
      .frame_start_o(frame_start_o), .vretrace_o(vretrace_o)
   );

   int checks = 0, failures = 0;
   exp_t q[$];

   int ex = 0, ey = 0, ecnt = 0;
   bit evr = 0, pb = 0, ps = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Driver: one pixel clock of stimulus plus its expected outcome.
   task automatic cyc(bit b, bit s);
      exp_t e;
      bit rb, rs;
      @(negedge clk);
      blank_in = b; sync_in = s;
      rb = b && !pb; rs = s && !ps;
      e.fs = rb && evr;                          // R7
      if (rb) begin
         if (evr) ey = (interlace_in && odd_field_in) ? 1 : 0;   // R7 R9
         else begin
            ey = ey + (interlace_in ? 2 : 1);    // R8
            if (ey > YMAX) ey = YMAX;
         end
         ex = 0; ecnt = 0; evr = 0;              // R3 R5 R6
      end else begin
         if (b && ex != XMAX) ex++;              // R3 R4
         if (rs && !b && ecnt < 2) begin         // R5 R6
            ecnt++;
            if (ecnt == 2) evr = 1;
         end
      end
      pb = b; ps = s;
      e.x = ex; e.y = ey; e.a = b; e.vr = evr;
      q.push_back(e);
   endtask

   task automatic line(int na, int nb, int pulses);
      for (int i = 0; i < na; i++) cyc(1, 0);
      cyc(0, 0);
      for (int p = 0; p < pulses; p++) begin cyc(0, 1); cyc(0, 0); end
      for (int i = 2 * pulses + 1; i < nb; i++) cyc(0, 0);
   endtask

   // Monitor: compare each result after the edge that produced it.
   always @(posedge clk) begin
      #1;
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk("R3/R4 pix_x", int'(pix_x_o), e.x);
         chk("R8 line_y", int'(line_y_o), e.y);
         chk("R2 active", int'(active_o), int'(e.a));
         chk("R7 frame_start", int'(frame_start_o), int'(e.fs));
         chk("R6 vretrace", int'(vretrace_o), int'(e.vr));
      end
   end

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset pix_x", int'(pix_x_o), 0);
      chk("R1 reset line_y", int'(line_y_o), 0);
      chk("R1 reset active", int'(active_o), 0);
      chk("R1 reset frame_start", int'(frame_start_o), 0);
      chk("R1 reset vretrace", int'(vretrace_o), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after reset vretrace", int'(vretrace_o), 0);
      chk("R1 after reset pix_x", int'(pix_x_o), 0);
      // progressive lines, no retrace yet
      line(4, 6, 0); line(5, 6, 0);
      // retrace with two pulses, then a frame (R6 R7 R8)
      line(3, 8, 2);
      line(6, 5, 0); line(6, 5, 0); line(6, 5, 0);
      // single pulses in separate blanking intervals (R5)
      line(4, 5, 1); line(4, 5, 1); line(4, 5, 0);
      // pulses inside active video ignored (R5)
      cyc(1, 0); cyc(1, 1); cyc(1, 0); cyc(1, 1);
      cyc(0, 0); cyc(0, 1); cyc(0, 0); cyc(0, 0);
      line(3, 4, 0);
      // three pulses: retrace stays set (R6)
      line(3, 10, 3); line(4, 4, 0);
      // interlaced, odd field (R9)
      interlace_in = 1'b1; odd_field_in = 1'b1;
      line(3, 6, 2); line(3, 4, 0); line(3, 4, 0);
      // interlaced, even field (R9)
      odd_field_in = 1'b0;
      line(3, 6, 2); line(3, 4, 0); line(3, 4, 0);
      // x saturation (R4)
      interlace_in = 1'b0;
      line(4100, 4, 0);
      // y saturation, interlaced even field (R8)
      interlace_in = 1'b1;
      line(2, 6, 2);
      for (int i = 0; i < 1030; i++) line(1, 2, 0);
      interlace_in = 1'b0;
      line(2, 3, 0);
      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule